// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped station-management master for Clause 22 PHY access. A processor reaches it through a small register bus that has a write strobe, an address, write data and combinational read data. Two 32-bit registers are visible on this bus. The command register holds a start/busy flag, a direction bit, a clock-range code, a PHY register number and a PHY address. The data register holds the 16-bit value to send, or the value returned by the PHY.

Software loads the data register when it wants a write. It then writes the command register with the busy flag set. The controller serialises one complete frame on the management clock and data lines, using a tri-state output enable on the data line. Software polls the busy flag, which the hardware clears when the frame ends. After a read, the captured value is in the data register. The clock-range code selects the divider that sets the management clock period.

Top module: `mdio_master`

## Requirements
- R1: After reset, both registers read zero, `mdc` is low and `mdio_oe` is low.
- R2: The command register sits at offset 0x10 and the data register at offset 0x14, in the low 16 bits. The command register layout is: bit 0 busy/start, bit 1 direction (1 = write), bits 4:2 clock-range code, bits 10:6 PHY register, bits 15:11 PHY address. All other bits read 0. Writing the command register with bit 0 clear stores the fields and starts nothing. Any other offset reads 0.
- R3: Writing the command register with bit 0 set while idle starts one 64-bit frame, sent MSB first. The frame is 32 ones, then start 01, then opcode (01 write, 10 read), then the 5-bit PHY address, then the 5-bit register number.
- R4: The management clock period in input clocks is 42, 62, 16, 26, 102 or 124 for codes 0 to 5, and 124 for codes 6 and 7. Each bit period starts with the low half, followed by an equal high half. `mdio_o` changes only when `mdc` falls or at the start of a frame.
- R5: A write frame drives turnaround 10 and then the 16 data bits with `mdio_oe` high throughout. The data sent is the data-register value at the moment the command was accepted, and a later write to the data register does not change it.
- R6: A read frame releases `mdio_oe` from the first turnaround bit (bit 46 of 64) to the end. It samples `mdio_i` on the rising `mdc` edge of each of the last 16 bits. Once busy clears, the data register holds the value sampled, first bit as MSB. This result replaces any data-register write made during the frame.
- R7: Busy clears by itself exactly 64 management-clock periods after the edge that accepted the command. From then on `mdc` is low and `mdio_oe` is low.
- R8: A command-register write while busy is set changes no field and does not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on `bus_addr`) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The assertions check several properties on every cycle. While idle, the lines stay quiet. During a frame, the data output holds between falling management-clock edges, and neither clock half exceeds the half period latched at start. In a read frame, the output enable stays released once it has been released. Command writes made while busy leave the stored fields untouched, and busy rises only after a command write with the start bit set. Only the bench's scenarios can show the frame bit sequence, the exact divider for each range code, the moment busy clears, that the write data is taken at issue time, and that the sampled read value reaches the data register.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef struct packed {
      logic [4:0] phy;
      logic [4:0] regn;
      logic [2:0] range;
      logic       wr;
   } mdio_cmd_t;

   // Half of the management clock period, in input clocks, per range code
   function automatic int unsigned mdc_half(input logic [2:0] code);
      case (code)
         3'd0:    return 21;
         3'd1:    return 31;
         3'd2:    return 8;
         3'd3:    return 13;
         3'd4:    return 51;
         default: return 62;
      endcase
   endfunction

   localparam int unsigned MDC_HALF_MAX = 62;

endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
   import mdio_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFF_CMD  = 'h10,
   parameter int OFF_DATA = 'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              busy,
   input  logic              rd_load,
   input  logic [15:0]       rd_val,
   output logic              start,
   output mdio_cmd_t         cmd_new,
   output mdio_cmd_t         cmd_q,
   output logic [15:0]       data_q
);

   logic hit_cmd, hit_data;
   logic unused_wdata;

   assign hit_cmd  = bus_we && (bus_addr == ADDR_W'(OFF_CMD));
   assign hit_data = bus_we && (bus_addr == ADDR_W'(OFF_DATA));
   assign unused_wdata = ^{bus_wdata[31:16], bus_wdata[5]};

   assign cmd_new.phy   = bus_wdata[15:11];
   assign cmd_new.regn  = bus_wdata[10:6];
   assign cmd_new.range = bus_wdata[4:2];
   assign cmd_new.wr    = bus_wdata[1];

   assign start = hit_cmd && bus_wdata[0] && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         data_q <= '0;
      end else begin
         if (hit_cmd && !busy)
            cmd_q <= cmd_new;
         if (rd_load)
            data_q <= rd_val;
         else if (hit_data)
            data_q <= bus_wdata[15:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFF_CMD))
         bus_rdata[15:0] = {cmd_q.phy, cmd_q.regn, 1'b0, cmd_q.range, cmd_q.wr, busy};
      else if (bus_addr == ADDR_W'(OFF_DATA))
         bus_rdata[15:0] = data_q;
   end

   // R8: fields frozen while a frame runs
   p_busy_cmd_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (hit_cmd && busy) |=> $stable(cmd_q));

   // R2: busy only rises after a command write carrying the start bit
   p_start_cause_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(hit_cmd && bus_wdata[0]));

endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
   import mdio_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       run,
   input  logic [2:0] code,
   output logic       mdc,
   output logic       rise,
   output logic       fall
);

   logic [CNT_W-1:0] cnt, half_q, full_m1, lvl;
   logic             mdc_d;

   assign full_m1 = (half_q << 1) - CNT_W'(1);
   assign rise    = run && (cnt == half_q - CNT_W'(1));
   assign fall    = run && (cnt == full_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         mdc    <= 1'b0;
         half_q <= CNT_W'(MDC_HALF_MAX);
      end else if (restart) begin
         cnt    <= '0;
         mdc    <= 1'b0;
         half_q <= CNT_W'(mdc_half(code));
      end else if (!run || fall) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= cnt + CNT_W'(1);
         if (rise)
            mdc <= 1'b1;
      end
   end

   // level-length monitor for the assertion below
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         lvl   <= '0;
         mdc_d <= 1'b0;
      end else begin
         mdc_d <= mdc;
         lvl   <= (mdc != mdc_d) ? CNT_W'(1) : lvl + CNT_W'(1);
      end
   end

   // R4: no clock half lasts longer than the selected half period
   p_mdc_level_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (lvl <= half_q));

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  mdio_cmd_t   cmd_new,
   input  logic [15:0] wdata,
   input  logic        rise,
   input  logic        fall,
   input  logic        mdio_i,
   output logic        busy,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        rd_load,
   output logic [15:0] rd_val
);

   localparam int FRAME    = PRE_LEN + 32;
   localparam int IDX_W    = $clog2(FRAME);
   localparam int TA_IDX   = PRE_LEN + 14;
   localparam int DATA_IDX = PRE_LEN + 16;

   logic [FRAME-1:0] shreg;
   logic [IDX_W-1:0] idx;
   logic             wr_q, last;
   logic [15:0]      cap;

   assign last    = (idx == IDX_W'(FRAME - 1));
   assign mdio_o  = busy && shreg[FRAME-1];
   assign mdio_oe = busy && (wr_q || (idx < IDX_W'(TA_IDX)));
   assign rd_load = busy && fall && last && !wr_q;
   assign rd_val  = cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         wr_q  <= 1'b0;
         shreg <= '0;
         cap   <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         idx   <= '0;
         wr_q  <= cmd_new.wr;
         cap   <= '0;
         shreg <= {{PRE_LEN{1'b1}}, 2'b01,
                   cmd_new.wr ? 2'b01 : 2'b10,
                   cmd_new.phy, cmd_new.regn,
                   cmd_new.wr ? 2'b10 : 2'b11,
                   cmd_new.wr ? wdata : 16'hFFFF};
      end else if (busy) begin
         if (rise && (idx >= IDX_W'(DATA_IDX)))
            cap <= {cap[14:0], mdio_i};
         if (fall) begin
            if (last)
               busy <= 1'b0;
            else begin
               idx   <= idx + IDX_W'(1);
               shreg <= shreg << 1;
            end
         end
      end
   end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFF_CMD  = 'h10,
   parameter int OFF_DATA = 'h14,
   parameter int PRE_LEN  = 32,
   parameter int CNT_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   if (PRE_LEN < 1 || PRE_LEN > 64) begin : g_bad_pre
      $error("PRE_LEN out of range");
   end
   if ((2 * MDC_HALF_MAX) >= (1 << CNT_W)) begin : g_bad_cnt
      $error("CNT_W too narrow for the largest divider");
   end
   if (OFF_CMD == OFF_DATA || OFF_CMD >= (1 << ADDR_W) || OFF_DATA >= (1 << ADDR_W)) begin : g_bad_map
      $error("register offsets invalid");
   end

   logic        start, busy, rise, fall, rd_load;
   logic [15:0] data_q, rd_val;
   mdio_cmd_t   cmd_new, cmd_q;

   mdio_regs #(.ADDR_W(ADDR_W), .OFF_CMD(OFF_CMD), .OFF_DATA(OFF_DATA)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
      .rd_load(rd_load), .rd_val(rd_val), .start(start),
      .cmd_new(cmd_new), .cmd_q(cmd_q), .data_q(data_q)
   );

   mdio_clkgen #(.CNT_W(CNT_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .restart(start), .run(busy),
      .code(cmd_new.range), .mdc(mdc), .rise(rise), .fall(fall)
   );

   mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_new(cmd_new),
      .wdata(data_q), .rise(rise), .fall(fall), .mdio_i(mdio_i),
      .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .rd_load(rd_load), .rd_val(rd_val)
   );

   // R7: quiet lines whenever no frame is running
   p_idle_quiet_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R4: data output holds between falling clock edges inside a frame
   p_out_stable_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));

   // R6: once released in a read frame, the line stays released
   p_read_release_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cmd_q.wr && $past(busy) && $past(!mdio_oe)) |-> !mdio_oe);

endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;

   localparam logic [7:0] A_CMD  = 8'h10;
   localparam logic [7:0] A_DATA = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = A_CMD;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mdio_master uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = A_CMD;
   endtask

   function automatic int period_of(input logic [2:0] code);
      case (code)
         3'd0: return 42;
         3'd1: return 62;
         3'd2: return 16;
         3'd3: return 26;
         3'd4: return 102;
         default: return 124;
      endcase
   endfunction

   // reference model: expected line values every cycle of one frame
   task automatic run_frame(input bit wr, input logic [2:0] code, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] wval,
                            input logic [15:0] phyval);
      int n, h, bad;
      logic [63:0] bits;
      logic [2:0]  first_act, first_exp;
      logic [31:0] cmd_word, bogus;
      string       tag;
      n = period_of(code);
      h = n / 2;
      bad = 0;
      first_act = '0; first_exp = '0;
      tag = wr ? "R3/R4/R5" : "R3/R4/R6";
      cmd_word = {16'b0, phy, rg, 1'b0, code, wr, 1'b0};
      bogus    = {16'b0, ~phy, ~rg, 1'b0, ~code, ~wr, 1'b1};
      bits = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
              (wr ? 2'b10 : 2'b00), (wr ? wval : 16'h0000)};
      bus_write(A_DATA, {16'b0, wval});
      bus_write(A_CMD, cmd_word | 32'h1);
      for (int k = 0; k < 64; k++) begin
         for (int j = 0; j < n; j++) begin
            logic e_mdc, e_oe, e_o;
            e_mdc = (j >= h);
            e_oe  = wr || (k < 46);
            e_o   = bits[63-k];
            if (mdc !== e_mdc || mdio_oe !== e_oe || (e_oe && mdio_o !== e_o)) begin
               if (bad == 0) begin
                  first_act = {mdc, mdio_oe, mdio_o};
                  first_exp = {e_mdc, e_oe, e_o};
               end
               bad++;
            end
            if (k == 20 && j == 0) begin
               chk(bus_rdata[0] === 1'b1, "R7", "busy mid-frame", bus_rdata, cmd_word | 32'h1);
               chk(bus_rdata === (cmd_word | 32'h1), "R8", "fields after busy write", bus_rdata, cmd_word | 32'h1);
            end
            bus_we = 1'b0; bus_addr = A_CMD;
            if (k == 5 && j == 0) begin
               bus_we = 1'b1; bus_wdata = bogus;
            end
            if (k == 10 && j == 0) begin
               bus_we = 1'b1; bus_addr = A_DATA; bus_wdata = {16'b0, wval ^ 16'h5A5A};
            end
            mdio_i = (!wr && k >= 48) ? phyval[63-k] : 1'b1;
            @(negedge clk);
         end
      end
      chk(bad == 0, tag, "frame waveform {mdc,oe,o}", {29'b0, first_act}, {29'b0, first_exp});
      chk(bus_rdata === cmd_word, "R7", "busy cleared after 64 periods", bus_rdata, cmd_word);
      chk(mdc === 1'b0 && mdio_oe === 1'b0, "R7", "lines idle after frame",
          {30'b0, mdc, mdio_oe}, 32'h0);
      bus_addr = A_DATA;
      #1;
      if (wr)
         chk(bus_rdata === {16'b0, wval ^ 16'h5A5A}, "R5", "data reg after write frame",
             bus_rdata, {16'b0, wval ^ 16'h5A5A});
      else
         chk(bus_rdata === {16'b0, phyval}, "R6", "read result in data reg",
             bus_rdata, {16'b0, phyval});
      bus_addr = A_CMD;
      mdio_i = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      bus_addr = A_CMD; #1;
      chk(bus_rdata === 32'h0, "R1", "command reg after reset", bus_rdata, 32'h0);
      bus_addr = A_DATA; #1;
      chk(bus_rdata === 32'h0, "R1", "data reg after reset", bus_rdata, 32'h0);
      chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "lines after reset", {30'b0, mdc, mdio_oe}, 32'h0);

      // R2: field store without start, layout, unmapped offset
      bus_write(A_CMD, 32'hFFFF_FFFE);
      #1;
      chk(bus_rdata === 32'h0000_FFDE, "R2", "command readback", bus_rdata, 32'h0000_FFDE);
      begin
         int act;
         act = 0;
         for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (mdc !== 1'b0 || mdio_oe !== 1'b0) act++;
         end
         chk(act == 0, "R2", "no frame without start bit", act, 0);
      end
      bus_write(A_DATA, 32'hABCD_1357);
      bus_addr = A_DATA; #1;
      chk(bus_rdata === 32'h0000_1357, "R2", "data readback", bus_rdata, 32'h0000_1357);
      bus_addr = 8'h18; #1;
      chk(bus_rdata === 32'h0, "R2", "unmapped offset", bus_rdata, 32'h0);
      bus_addr = A_CMD;

      run_frame(1'b1, 3'd2, 5'h11, 5'h0A, 16'hBEEF, 16'h0000);
      run_frame(1'b0, 3'd3, 5'h03, 5'h1F, 16'h1111, 16'hA55A);
      run_frame(1'b1, 3'd0, 5'h00, 5'h00, 16'h0001, 16'h0000);
      run_frame(1'b0, 3'd1, 5'h1F, 5'h01, 16'h2222, 16'h8001);
      run_frame(1'b1, 3'd4, 5'h15, 5'h0E, 16'h7FFE, 16'h0000);
      run_frame(1'b0, 3'd5, 5'h0C, 5'h13, 16'h3333, 16'h1234);
      run_frame(1'b0, 3'd6, 5'h1A, 5'h05, 16'h4444, 16'hC3C3);
      run_frame(1'b1, 3'd7, 5'h07, 5'h18, 16'h0000, 16'h0000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule